// File: doc/BRIEF.md
# Data Access Protection Checker

This block decides, in the same cycle as the access, whether a data load or store may proceed under the current protection setup. It compares the access address with several programmable windows and grants the access if any of them applies. The windows are a set of instruction regions that only loads may use, a set of data regions with separate read and write permission, a stack window, and a peripheral window built from a base and a mask. Checking applies only while protection is switched on. While it is off, every access passes.

When a strobed access is refused, the block updates a fault record on the next clock edge. A refused load, and a refused store outside the peripheral window, both store the address, the task number and a cause field. They also set the fault code 0x431 and raise a one-cycle redirect that carries the trap vector. A refused store inside the peripheral window goes to a separate peripheral record instead. That record holds the program counter and the task number, the fault code becomes 0x432, and no redirect is raised. The memory access itself and instruction-fetch protection are handled elsewhere.

Top module: `mem_guard`

## Requirements
- R1: While `prot_en` is low, `acc_allow` is 1 for every address and direction, and a strobed access changes no record.
- R2: A load is granted when lo <= address <= hi (bounds inclusive) for an instruction region whose enable and read bits are both set. Instruction regions never grant a store.
- R3: A data region grants a load when its enable and read bits are set, and a store when its enable and write bits are set. Both cases need lo <= address <= hi, bounds inclusive.
- R4: While `sp_only` is high, data regions grant only accesses with `acc_via_sp` high. Instruction, stack and peripheral windows are not affected by `sp_only`.
- R5: The peripheral window spans from (`per_base` AND NOT `per_mask`) to (`per_base` OR `per_mask`), bounds inclusive. It always grants loads, and it grants stores only while `per_wr_en` is high.
- R6: The stack window `stk_lo` <= address <= `stk_hi` grants both loads and stores.
- R7: A strobed, refused load sets `mem_cause` to 3'b001 on the next edge. The encoding is bit0 read, bit1 write, bit2 execute, so the write and execute bits are cleared. The same edge records the address and task, sets `fault_code` to 0x431, and raises `redirect` for one cycle with `redirect_vec` = TRAP_VEC (0x30).
- R8: A strobed, refused store outside the peripheral window sets `mem_cause` to 3'b010 and records the address and task. It also sets `fault_code` to 0x431 and raises `redirect` with vector 0x30.
- R9: A strobed, refused store inside the peripheral window sets `fault_code` to 0x432 and records `cur_pc` and the task in `per_pc_rec`/`per_tid_rec`. It leaves the memory record unchanged and raises no redirect.
- R10: After reset, all records, `fault_code`, `redirect` and `redirect_vec` are zero. Records change only on an edge where `acc_valid` is high and the access is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| prot_en | input | 1 | Data protection switched on |
| acc_valid | input | 1 | Access strobe |
| acc_addr | input | AW | Access address |
| acc_write | input | 1 | 1 = store, 0 = load |
| acc_via_sp | input | 1 | Base register is the stack pointer |
| cur_pc | input | AW | Program counter of the access |
| task_id | input | TW | Current task number |
| ireg_lo | input | NI*AW | Instruction region lower bounds, region i at [i*AW +: AW] |
| ireg_hi | input | NI*AW | Instruction region upper bounds |
| ireg_en | input | NI | Instruction region enables |
| ireg_rd | input | NI | Instruction region read permits |
| dreg_lo | input | ND*AW | Data region lower bounds |
| dreg_hi | input | ND*AW | Data region upper bounds |
| dreg_en | input | ND | Data region enables |
| dreg_rd | input | ND | Data region read permits |
| dreg_wr | input | ND | Data region write permits |
| sp_only | input | 1 | Restrict data regions to stack-pointer accesses |
| stk_lo | input | AW | Stack window lower limit |
| stk_hi | input | AW | Stack window upper limit |
| per_base | input | AW | Peripheral window base |
| per_mask | input | AW | Peripheral window mask |
| per_wr_en | input | 1 | Peripheral window accepts stores |
| acc_allow | output | 1 | Access granted (combinational) |
| fault_code | output | 12 | Last fault code |
| redirect | output | 1 | One-cycle trap request |
| redirect_vec | output | AW | Trap vector while redirect is high |
| mem_cause | output | 3 | Memory violation cause, bit0 read, bit1 write, bit2 execute |
| mem_addr_rec | output | AW | Recorded violating address |
| mem_tid_rec | output | TW | Recorded task of memory violation |
| per_pc_rec | output | AW | Recorded PC of peripheral violation |
| per_tid_rec | output | TW | Recorded task of peripheral violation |

## Verification
A wrong grant term shows up at `acc_allow` in the same cycle, for exactly the addresses of the affected window. Examples are a bound compare that is off by one, a read and write permit swapped, or `sp_only` applied to the wrong window. A sweep over every address of a narrow-address configuration therefore exposes it directly at the bound addresses. A wrong fault classification shows one edge after the strobe. Examples are a peripheral store routed to the memory record, a stale cause bit, or a missing redirect. It appears as a wrong `fault_code`, `mem_cause` or `redirect`, and the record values persist until the next refused strobe.

// File: rtl/mem_guard_pkg.sv
package mem_guard_pkg;

    localparam int CODE_W = 12;
    localparam int CAUSE_W = 3;

    // cause field positions
    localparam int CAUSE_RD = 0;
    localparam int CAUSE_WR = 1;
    localparam int CAUSE_EX = 2;

    localparam logic [CODE_W-1:0] CODE_MEM = 12'h431;
    localparam logic [CODE_W-1:0] CODE_PER = 12'h432;

    // classification of the current access
    typedef enum logic [1:0] {
        FK_GRANT  = 2'd0,  // access allowed, nothing to record
        FK_MEM_RD = 2'd1,  // refused load
        FK_MEM_WR = 2'd2,  // refused store outside peripheral window
        FK_PER_WR = 2'd3   // refused store inside peripheral window
    } fault_kind_e;

endpackage

// File: rtl/mg_range_bank.sv
module mg_range_bank #(
    parameter int N  = 4,
    parameter int AW = 32
) (
    input  logic [AW-1:0]   addr,
    input  logic [N*AW-1:0] lo,
    input  logic [N*AW-1:0] hi,
    input  logic [N-1:0]    grant,
    output logic            hit
);
    logic [N-1:0] hit_vec;

    for (genvar g = 0; g < N; g++) begin : g_reg
        logic [AW-1:0] lo_g;
        logic [AW-1:0] hi_g;
        assign lo_g = lo[g*AW +: AW];
        assign hi_g = hi[g*AW +: AW];
        assign hit_vec[g] = grant[g] && (addr >= lo_g) && (addr <= hi_g);
    end

    assign hit = |hit_vec;
endmodule

// File: rtl/mg_decide.sv
module mg_decide
    import mem_guard_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          prot_en,
    input  logic          write,
    input  logic          via_sp,
    input  logic          sp_only,
    input  logic [AW-1:0] addr,
    input  logic          ins_hit,
    input  logic          dat_hit,
    input  logic [AW-1:0] stk_lo,
    input  logic [AW-1:0] stk_hi,
    input  logic [AW-1:0] per_base,
    input  logic [AW-1:0] per_mask,
    input  logic          per_wr_en,
    output logic          allow,
    output fault_kind_e   kind
);
    logic [AW-1:0] per_lo;
    logic [AW-1:0] per_hi;
    logic          in_per;
    logic          in_stk;
    logic          dat_ok;
    logic          per_ok;
    logic          ok;

    assign per_lo = per_base & ~per_mask;
    assign per_hi = per_base | per_mask;
    assign in_per = (addr >= per_lo) && (addr <= per_hi);
    assign in_stk = (addr >= stk_lo) && (addr <= stk_hi);
    assign dat_ok = dat_hit && (!sp_only || via_sp);
    assign per_ok = in_per && (!write || per_wr_en);

    always_comb begin
        ok = per_ok || in_stk || dat_ok;
        if (!write) begin
            ok = ok || ins_hit;
        end
    end

    assign allow = !prot_en || ok;

    always_comb begin
        if (allow) begin
            kind = FK_GRANT;
        end else if (!write) begin
            kind = FK_MEM_RD;
        end else if (in_per) begin
            kind = FK_PER_WR;
        end else begin
            kind = FK_MEM_WR;
        end
    end
endmodule

// File: rtl/mg_fault_rec.sv
module mg_fault_rec
    import mem_guard_pkg::*;
#(
    parameter int AW = 32,
    parameter int TW = 8,
    parameter logic [AW-1:0] TRAP_VEC = 'h30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               strobe,
    input  fault_kind_e        kind,
    input  logic [AW-1:0]      addr,
    input  logic [AW-1:0]      pc,
    input  logic [TW-1:0]      tid,
    output logic [CODE_W-1:0]  fault_code,
    output logic               redirect,
    output logic [AW-1:0]      redirect_vec,
    output logic [CAUSE_W-1:0] mem_cause,
    output logic [AW-1:0]      mem_addr_rec,
    output logic [TW-1:0]      mem_tid_rec,
    output logic [AW-1:0]      per_pc_rec,
    output logic [TW-1:0]      per_tid_rec
);
    fault_kind_e ev;

    assign ev = strobe ? kind : FK_GRANT;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fault_code   <= '0;
            redirect     <= 1'b0;
            redirect_vec <= '0;
            mem_cause    <= '0;
            mem_addr_rec <= '0;
            mem_tid_rec  <= '0;
            per_pc_rec   <= '0;
            per_tid_rec  <= '0;
        end else begin
            redirect     <= 1'b0;
            redirect_vec <= '0;
            unique case (ev)
                FK_GRANT: begin
                end
                FK_MEM_RD: begin
                    fault_code             <= CODE_MEM;
                    mem_cause[CAUSE_WR]    <= 1'b0;
                    mem_cause[CAUSE_EX]    <= 1'b0;
                    mem_cause[CAUSE_RD]    <= 1'b1;
                    mem_addr_rec           <= addr;
                    mem_tid_rec            <= tid;
                    redirect               <= 1'b1;
                    redirect_vec           <= TRAP_VEC;
                end
                FK_MEM_WR: begin
                    fault_code             <= CODE_MEM;
                    mem_cause[CAUSE_RD]    <= 1'b0;
                    mem_cause[CAUSE_EX]    <= 1'b0;
                    mem_cause[CAUSE_WR]    <= 1'b1;
                    mem_addr_rec           <= addr;
                    mem_tid_rec            <= tid;
                    redirect               <= 1'b1;
                    redirect_vec           <= TRAP_VEC;
                end
                FK_PER_WR: begin
                    fault_code  <= CODE_PER;
                    per_pc_rec  <= pc;
                    per_tid_rec <= tid;
                end
                default: begin
                end
            endcase
        end
    end
endmodule

// File: rtl/mem_guard.sv
module mem_guard
    import mem_guard_pkg::*;
#(
    parameter int AW = 32,
    parameter int TW = 8,
    parameter int NI = 4,
    parameter int ND = 4,
    parameter logic [AW-1:0] TRAP_VEC = 'h30
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               prot_en,
    input  logic               acc_valid,
    input  logic [AW-1:0]      acc_addr,
    input  logic               acc_write,
    input  logic               acc_via_sp,
    input  logic [AW-1:0]      cur_pc,
    input  logic [TW-1:0]      task_id,
    input  logic [NI*AW-1:0]   ireg_lo,
    input  logic [NI*AW-1:0]   ireg_hi,
    input  logic [NI-1:0]      ireg_en,
    input  logic [NI-1:0]      ireg_rd,
    input  logic [ND*AW-1:0]   dreg_lo,
    input  logic [ND*AW-1:0]   dreg_hi,
    input  logic [ND-1:0]      dreg_en,
    input  logic [ND-1:0]      dreg_rd,
    input  logic [ND-1:0]      dreg_wr,
    input  logic               sp_only,
    input  logic [AW-1:0]      stk_lo,
    input  logic [AW-1:0]      stk_hi,
    input  logic [AW-1:0]      per_base,
    input  logic [AW-1:0]      per_mask,
    input  logic               per_wr_en,
    output logic               acc_allow,
    output logic [CODE_W-1:0]  fault_code,
    output logic               redirect,
    output logic [AW-1:0]      redirect_vec,
    output logic [CAUSE_W-1:0] mem_cause,
    output logic [AW-1:0]      mem_addr_rec,
    output logic [TW-1:0]      mem_tid_rec,
    output logic [AW-1:0]      per_pc_rec,
    output logic [TW-1:0]      per_tid_rec
);
    logic [NI-1:0] ins_grant;
    logic [ND-1:0] dat_grant;
    logic          ins_hit;
    logic          dat_hit;
    fault_kind_e   kind;

    assign ins_grant = ireg_en & ireg_rd;
    assign dat_grant = dreg_en & (acc_write ? dreg_wr : dreg_rd);

    mg_range_bank #(.N(NI), .AW(AW)) u_ins (
        .addr  (acc_addr),
        .lo    (ireg_lo),
        .hi    (ireg_hi),
        .grant (ins_grant),
        .hit   (ins_hit)
    );

    mg_range_bank #(.N(ND), .AW(AW)) u_dat (
        .addr  (acc_addr),
        .lo    (dreg_lo),
        .hi    (dreg_hi),
        .grant (dat_grant),
        .hit   (dat_hit)
    );

    mg_decide #(.AW(AW)) u_dec (
        .prot_en   (prot_en),
        .write     (acc_write),
        .via_sp    (acc_via_sp),
        .sp_only   (sp_only),
        .addr      (acc_addr),
        .ins_hit   (ins_hit),
        .dat_hit   (dat_hit),
        .stk_lo    (stk_lo),
        .stk_hi    (stk_hi),
        .per_base  (per_base),
        .per_mask  (per_mask),
        .per_wr_en (per_wr_en),
        .allow     (acc_allow),
        .kind      (kind)
    );

    mg_fault_rec #(.AW(AW), .TW(TW), .TRAP_VEC(TRAP_VEC)) u_rec (
        .clk          (clk),
        .rst_n        (rst_n),
        .strobe       (acc_valid),
        .kind         (kind),
        .addr         (acc_addr),
        .pc           (cur_pc),
        .tid          (task_id),
        .fault_code   (fault_code),
        .redirect     (redirect),
        .redirect_vec (redirect_vec),
        .mem_cause    (mem_cause),
        .mem_addr_rec (mem_addr_rec),
        .mem_tid_rec  (mem_tid_rec),
        .per_pc_rec   (per_pc_rec),
        .per_tid_rec  (per_tid_rec)
    );
endmodule

// File: rtl/mem_guard_chk.sv
module mem_guard_chk #(
    parameter int AW = 32,
    parameter int TW = 8,
    parameter int NI = 4,
    parameter logic [AW-1:0] TRAP_VEC = 'h30
) (
    input logic            clk,
    input logic            rst_n,
    input logic            prot_en,
    input logic            acc_valid,
    input logic [AW-1:0]   acc_addr,
    input logic            acc_write,
    input logic            acc_via_sp,
    input logic            sp_only,
    input logic [NI-1:0]   ireg_en,
    input logic [AW-1:0]   stk_lo,
    input logic [AW-1:0]   stk_hi,
    input logic [AW-1:0]   per_base,
    input logic [AW-1:0]   per_mask,
    input logic            acc_allow,
    input logic [11:0]     fault_code,
    input logic            redirect,
    input logic [AW-1:0]   redirect_vec,
    input logic [2:0]      mem_cause,
    input logic [AW-1:0]   mem_addr_rec,
    input logic [TW-1:0]   per_tid_rec
);
    logic in_per;
    logic in_stk;
    logic refused;

    assign in_per  = (acc_addr >= (per_base & ~per_mask)) && (acc_addr <= (per_base | per_mask));
    assign in_stk  = (acc_addr >= stk_lo) && (acc_addr <= stk_hi);
    assign refused = acc_valid && !acc_allow;

    a_r1_off_grants: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_en |-> acc_allow);

    a_r4_sp_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_en && sp_only && !acc_via_sp && ireg_en == '0 && !in_stk && !in_per) |-> !acc_allow);

    a_r7_load_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (refused && !acc_write) |=> (mem_cause == 3'b001 && fault_code == 12'h431
                                     && redirect && redirect_vec == TRAP_VEC));

    a_r8_store_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (refused && acc_write && !in_per) |=> (mem_cause == 3'b010 && fault_code == 12'h431 && redirect));

    a_r9_per_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (refused && acc_write && in_per) |=> (fault_code == 12'h432 && !redirect && $stable(mem_addr_rec)));

    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !refused |=> ($stable(mem_addr_rec) && $stable(fault_code) && $stable(per_tid_rec) && !redirect));
endmodule

bind mem_guard mem_guard_chk #(.AW(AW), .TW(TW), .NI(NI), .TRAP_VEC(TRAP_VEC)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .prot_en      (prot_en),
    .acc_valid    (acc_valid),
    .acc_addr     (acc_addr),
    .acc_write    (acc_write),
    .acc_via_sp   (acc_via_sp),
    .sp_only      (sp_only),
    .ireg_en      (ireg_en),
    .stk_lo       (stk_lo),
    .stk_hi       (stk_hi),
    .per_base     (per_base),
    .per_mask     (per_mask),
    .acc_allow    (acc_allow),
    .fault_code   (fault_code),
    .redirect     (redirect),
    .redirect_vec (redirect_vec),
    .mem_cause    (mem_cause),
    .mem_addr_rec (mem_addr_rec),
    .per_tid_rec  (per_tid_rec)
);

// File: tb/tb_mem_guard.sv
`timescale 1ns/1ps
module tb_mem_guard;
    localparam int AW = 8;
    localparam int TW = 8;
    localparam int NI = 4;
    localparam int ND = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            prot_en = 1'b0;
    logic            acc_valid = 1'b0;
    logic [AW-1:0]   acc_addr = '0;
    logic            acc_write = 1'b0;
    logic            acc_via_sp = 1'b0;
    logic [AW-1:0]   cur_pc = '0;
    logic [TW-1:0]   task_id = '0;
    logic [NI*AW-1:0] ireg_lo, ireg_hi;
    logic [NI-1:0]   ireg_en, ireg_rd;
    logic [ND*AW-1:0] dreg_lo, dreg_hi;
    logic [ND-1:0]   dreg_en, dreg_rd, dreg_wr;
    logic            sp_only = 1'b0;
    logic [AW-1:0]   stk_lo = 8'hC0, stk_hi = 8'hCF;
    logic [AW-1:0]   per_base = 8'hE5, per_mask = 8'h0F;
    logic            per_wr_en = 1'b0;
    logic            acc_allow;
    logic [11:0]     fault_code;
    logic            redirect;
    logic [AW-1:0]   redirect_vec;
    logic [2:0]      mem_cause;
    logic [AW-1:0]   mem_addr_rec;
    logic [TW-1:0]   mem_tid_rec;
    logic [AW-1:0]   per_pc_rec;
    logic [TW-1:0]   per_tid_rec;

    int n_chk = 0;
    int n_bad = 0;

    // region table of the bench configuration
    int ilo[4] = '{'h10, 'h20, 'h30, 'h40};
    int ihi[4] = '{'h1F, 'h2F, 'h3F, 'h47};
    bit ien[4] = '{1, 1, 0, 1};
    bit ird[4] = '{1, 0, 1, 1};
    int dlo[4] = '{'h50, 'h60, 'h70, 'h80};
    int dhi[4] = '{'h5F, 'h6F, 'h7F, 'h8F};
    bit den[4] = '{1, 1, 1, 0};
    bit drd[4] = '{1, 1, 0, 1};
    bit dwr[4] = '{1, 0, 1, 1};

    always #2.5 clk = ~clk;

    mem_guard #(.AW(AW), .TW(TW), .NI(NI), .ND(ND), .TRAP_VEC(8'h30)) dut (.*);

    initial begin
        for (int i = 0; i < 4; i++) begin
            ireg_lo[i*AW +: AW] = AW'(ilo[i]);
            ireg_hi[i*AW +: AW] = AW'(ihi[i]);
            ireg_en[i] = ien[i];
            ireg_rd[i] = ird[i];
            dreg_lo[i*AW +: AW] = AW'(dlo[i]);
            dreg_hi[i*AW +: AW] = AW'(dhi[i]);
            dreg_en[i] = den[i];
            dreg_rd[i] = drd[i];
            dreg_wr[i] = dwr[i];
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit exp_allow(int a, bit wr, bit sp, bit spo, bit pwe, bit en);
        bit ok;
        int plo, phi;
        if (!en) return 1'b1;
        plo = 'hE5 & ~'h0F & 'hFF;
        phi = 'hE5 | 'h0F;
        ok = 1'b0;
        if (a >= plo && a <= phi && (!wr || pwe)) ok = 1'b1;
        if (a >= 'hC0 && a <= 'hCF) ok = 1'b1;
        for (int i = 0; i < 4; i++) begin
            if (!wr && ien[i] && ird[i] && a >= ilo[i] && a <= ihi[i]) ok = 1'b1;
            if (den[i] && (wr ? dwr[i] : drd[i]) && a >= dlo[i] && a <= dhi[i] && (!spo || sp)) ok = 1'b1;
        end
        return ok;
    endfunction

    function automatic string req_of(int a, bit spo, bit en);
        if (!en) return "R1";
        if (a >= 'hE0 && a <= 'hEF) return "R5";
        if (a >= 'hC0 && a <= 'hCF) return "R6";
        if (a >= 'h10 && a <= 'h47) return "R2";
        if (spo) return "R4";
        return "R3";
    endfunction

    // one strobed access: drive at falling edge, result visible at next falling edge
    task automatic strobe(bit wr, int a, int tid, int pc);
        acc_write = wr;
        acc_addr  = AW'(a);
        task_id   = TW'(tid);
        cur_pc    = AW'(pc);
        acc_valid = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset values
        check("R10", "reset code", int'(fault_code), 0);
        check("R10", "reset redirect", int'(redirect), 0);
        check("R10", "reset cause", int'(mem_cause), 0);
        check("R10", "reset addr", int'(mem_addr_rec), 0);
        check("R10", "reset per pc", int'(per_pc_rec), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // exhaustive grant sweep, strobe low so no record changes
        for (int cfg = 0; cfg < 16; cfg++) begin
            prot_en    = cfg[0];
            sp_only    = cfg[1];
            per_wr_en  = cfg[2];
            acc_via_sp = cfg[3];
            for (int wr = 0; wr < 2; wr++) begin
                for (int a = 0; a < 256; a++) begin
                    acc_write = wr[0];
                    acc_addr  = AW'(a);
                    #0.1;
                    check(req_of(a, cfg[1], cfg[0]), $sformatf("allow a=%0h wr=%0d cfg=%0d", a, wr, cfg),
                          int'(acc_allow), int'(exp_allow(a, wr[0], cfg[3], cfg[1], cfg[2], cfg[0])));
                end
            end
        end
        @(negedge clk);
        check("R10", "sweep left record", int'(mem_addr_rec), 0);

        prot_en = 1'b1; sp_only = 1'b0; per_wr_en = 1'b0; acc_via_sp = 1'b0;
        @(negedge clk);

        // R7 refused load
        strobe(1'b0, 'h90, 5, 'h11);
        check("R7", "code", int'(fault_code), 'h431);
        check("R7", "cause", int'(mem_cause), 'b001);
        check("R7", "addr", int'(mem_addr_rec), 'h90);
        check("R7", "tid", int'(mem_tid_rec), 5);
        check("R7", "redirect", int'(redirect), 1);
        check("R7", "vector", int'(redirect_vec), 'h30);
        @(negedge clk);
        check("R7", "redirect one cycle", int'(redirect), 0);

        // R8 refused store outside peripheral window
        strobe(1'b1, 'h95, 6, 'h12);
        check("R8", "code", int'(fault_code), 'h431);
        check("R8", "cause", int'(mem_cause), 'b010);
        check("R8", "addr", int'(mem_addr_rec), 'h95);
        check("R8", "tid", int'(mem_tid_rec), 6);
        check("R8", "redirect", int'(redirect), 1);

        // R7 load after store clears write bit
        strobe(1'b0, 'h96, 7, 'h13);
        check("R7", "cause write cleared", int'(mem_cause), 'b001);

        // R9 refused store in peripheral window
        strobe(1'b1, 'hE3, 9, 'hAB);
        check("R9", "code", int'(fault_code), 'h432);
        check("R9", "pc", int'(per_pc_rec), 'hAB);
        check("R9", "tid", int'(per_tid_rec), 9);
        check("R9", "no redirect", int'(redirect), 0);
        check("R9", "mem addr kept", int'(mem_addr_rec), 'h96);
        check("R9", "mem cause kept", int'(mem_cause), 'b001);

        // R10 refused access without strobe
        acc_write = 1'b0; acc_addr = 8'h91; task_id = 8'h22;
        @(negedge clk);
        check("R10", "no strobe addr", int'(mem_addr_rec), 'h96);
        check("R10", "no strobe code", int'(fault_code), 'h432);
        check("R10", "no strobe redirect", int'(redirect), 0);

        // R10 granted strobed access
        strobe(1'b0, 'h10, 3, 'h14);
        check("R10", "granted addr", int'(mem_addr_rec), 'h96);
        check("R10", "granted redirect", int'(redirect), 0);

        // R1 protection off
        prot_en = 1'b0;
        strobe(1'b1, 'h91, 4, 'h15);
        check("R1", "off addr", int'(mem_addr_rec), 'h96);
        check("R1", "off code", int'(fault_code), 'h432);
        check("R1", "off redirect", int'(redirect), 0);

        // R5 store in peripheral with write enable is granted
        prot_en = 1'b1; per_wr_en = 1'b1;
        strobe(1'b1, 'hEF, 8, 'h16);
        check("R5", "per store granted code", int'(fault_code), 'h432);
        check("R5", "per store granted pc", int'(per_pc_rec), 'hAB);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule